// File: doc/BRIEF.md
# SRAM Self-Test Sequencer

This block is a synchronous built-in test controller for a single-port, byte-wide static RAM. A pulse on `start` launches a fixed series of pattern passes over the whole array. The block drives address, write data, write enable and read enable. Read data comes back a fixed, parameterised number of cycles after each read request.

There are two kinds of pass. Per-location passes write a value and read it back at once, which checks the data lines and each cell. Fill-then-verify passes first write the whole array and only then read it back. Because their data never repeats across the array, they expose address lines that are shorted, stuck or aliased, which per-location passes cannot see.

On the first miscompare the block stops. It holds the failing address, the expected and actual bytes and a pass code, and raises `done` with `fail`. If every pass succeeds, it raises `done` with `fail` low.

Top module: `sramSelfTest`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `memWe` and `memRe` are all low.
- R2: A `start` pulse while idle or done begins a new run and clears `done` and `fail`. A `start` while `busy` is high is ignored, and the run's length is unchanged.
- R3: `memWe` and `memRe` are never high in the same cycle. Read data is compared in the cycle exactly `RD_LAT` cycles after the cycle in which `memRe` is high.
- R4: The passes run in this order, with these codes: zeros 0, ones 1, alternating 2, walking-one 3, walking-zero 4, address-plus-offset 5, Fibonacci 6. Every address is visited in every pass.
  - A per-location step is one write cycle, one read cycle and `RD_LAT` wait cycles.
  - A fill pass takes one cycle per write, then `1+RD_LAT` cycles per read.
  - A clean run therefore keeps `busy` high for N*(4+2*DATA_W)*(2+RD_LAT) + 2*N*(2+RD_LAT) cycles, with N = 2^ADDR_W.
- R5: The solid passes write and check 0x00, then all-ones, at each address.
- R6: The alternating pass writes and checks 0x55 (bit 0 set), then 0xAA, at each address before moving on.
- R7: At each address, the walking-one pass checks 1<<k for k ascending from 0. The walking-zero pass checks ~(1<<k) in the same way, and starts only after walking-one has covered the whole array.
- R8: The address pass writes (address + 11) mod 2^DATA_W to every location in ascending order. Only then does it read back and compare every location, in ascending order.
- R9: The Fibonacci pass fills location i with term i of the sequence seeded 1, 1 with unsigned wrap-around. It verifies by regenerating the sequence from the seed.
- R10: On a miscompare the block stops. It latches the address, the expected byte, the read byte and the pass code, then shows `done` and `fail` high and `busy` low until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (held until next start) |
| fail | output | 1 | Run finished on a miscompare |
| failAddr | output | ADDR_W | Address of the miscompare |
| failExpect | output | DATA_W | Expected byte at the miscompare |
| failActual | output | DATA_W | Byte read at the miscompare |
| failPass | output | 3 | Pass code at the miscompare |
| memAddr | output | ADDR_W | RAM address |
| memWdata | output | DATA_W | RAM write data |
| memRdata | input | DATA_W | RAM read data, RD_LAT cycles after read enable |
| memWe | output | 1 | RAM write enable |
| memRe | output | 1 | RAM read enable |

## Verification
The hardest situation to reach from the ports is a fault that passes every per-location test and shows up only when the whole array is filled before it is read. The bench's RAM model can ignore its top address bit, or wire-AND its two upper address bits together. In both cases later fill writes overwrite earlier ones, so the first verify read at address 0 returns 0x2B where 0x0B is expected.

Further data-line faults are injected to stop the run inside each earlier pass:
- a stuck bit,
- a shorted pair that the alternating patterns cannot reveal,
- a cell that is sensitive to one particular pattern.

Each of these stops the run at a known pass, address and byte pair.

// File: rtl/sramTestPkg.sv
package sramTestPkg;

  typedef enum logic [2:0] {
    PASS_ZERO  = 3'd0,
    PASS_ONES  = 3'd1,
    PASS_ALT   = 3'd2,
    PASS_WALK1 = 3'd3,
    PASS_WALK0 = 3'd4,
    PASS_ADDR  = 3'd5,
    PASS_FIB   = 3'd6
  } passT;

  // strobes from control to datapath
  typedef struct packed {
    logic clrPos;   // back to address 0, variant 0, sequence seed
    logic incSub;   // next variant at the same address
    logic incAddr;  // next address, variant 0, next sequence term
    logic capture;  // latch miscompare details
  } strobeT;

endpackage

// File: rtl/sramTestDp.sv
module sramTestDp
  import sramTestPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int OFFSET = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  passT              pass,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] pattern,
  output logic              lastSub,
  output logic              lastAddr,
  output logic              mismatch,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failAct,
  output logic [2:0]        failPass
);

  localparam int SUB_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam int SUM_W = ((ADDR_W > DATA_W) ? ADDR_W : DATA_W) + 1;

  logic [SUB_W-1:0]  sub;
  logic [DATA_W-1:0] fibCur, fibNxt;
  logic [DATA_W-1:0] altPat, walkBit;
  logic [SUM_W-1:0]  addrSum;

  // alternating pattern: even bit positions set
  for (genvar i = 0; i < DATA_W; i++) begin : g_alt
    assign altPat[i] = ((i % 2) == 0);
  end

  assign walkBit = DATA_W'(1) << sub;
  assign addrSum = SUM_W'(addr) + SUM_W'(OFFSET);

  always_comb begin
    unique case (pass)
      PASS_ZERO:  pattern = '0;
      PASS_ONES:  pattern = '1;
      PASS_ALT:   pattern = sub[0] ? ~altPat : altPat;
      PASS_WALK1: pattern = walkBit;
      PASS_WALK0: pattern = ~walkBit;
      PASS_ADDR:  pattern = addrSum[DATA_W-1:0];
      default:    pattern = fibCur;
    endcase
  end

  always_comb begin
    unique case (pass)
      PASS_ALT:               lastSub = (sub == SUB_W'(1));
      PASS_WALK1, PASS_WALK0: lastSub = (sub == SUB_W'(DATA_W-1));
      default:                lastSub = 1'b1;
    endcase
  end

  assign lastAddr = &addr;
  assign mismatch = (rdData != pattern);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr   <= '0;
      sub    <= '0;
      fibCur <= DATA_W'(1);
      fibNxt <= DATA_W'(1);
    end else if (stb.clrPos) begin
      addr   <= '0;
      sub    <= '0;
      fibCur <= DATA_W'(1);
      fibNxt <= DATA_W'(1);
    end else if (stb.incAddr) begin
      addr   <= addr + ADDR_W'(1);
      sub    <= '0;
      fibCur <= fibNxt;
      fibNxt <= fibCur + fibNxt;
    end else if (stb.incSub) begin
      sub    <= sub + SUB_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failAddr <= '0;
      failExp  <= '0;
      failAct  <= '0;
      failPass <= '0;
    end else if (stb.capture) begin
      failAddr <= addr;
      failExp  <= pattern;
      failAct  <= rdData;
      failPass <= pass;
    end
  end

  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.incAddr && !stb.clrPos |=> addr == $past(addr) + ADDR_W'(1))
    else $error("address did not advance by one");

  p_sub_limit_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.incSub && lastSub))
    else $error("variant stepped past its last value");

  p_fib_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.incAddr && !stb.clrPos |=> fibCur == $past(fibNxt))
    else $error("sequence term did not advance");

endmodule

// File: rtl/sramTestCtrl.sv
module sramTestCtrl
  import sramTestPkg::*;
#(
  parameter int RD_LAT = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   lastSub,
  input  logic   lastAddr,
  input  logic   mismatch,
  output strobeT stb,
  output passT   pass,
  output logic   memWe,
  output logic   memRe,
  output logic   busy,
  output logic   done,
  output logic   fail
);

  localparam int CNT_W = $clog2(RD_LAT + 1);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_RD, S_WAIT, S_DONE} stateT;

  stateT            state, stateN;
  passT             passN;
  logic [CNT_W-1:0] waitCnt, waitN;
  logic             doneN, failN, fillPass, advPass;

  assign fillPass = (pass == PASS_ADDR) || (pass == PASS_FIB);

  always_comb begin
    stateN  = state;
    passN   = pass;
    waitN   = waitCnt;
    doneN   = done;
    failN   = fail;
    stb     = '0;
    advPass = 1'b0;
    unique case (state)
      S_IDLE, S_DONE: if (start) begin
        stb.clrPos = 1'b1;
        passN      = PASS_ZERO;
        doneN      = 1'b0;
        failN      = 1'b0;
        stateN     = S_WR;
      end
      S_WR: begin
        if (!fillPass) begin
          stateN = S_RD;
        end else if (lastAddr) begin
          stb.clrPos = 1'b1;           // fill finished: verify from address 0
          stateN     = S_RD;
        end else begin
          stb.incAddr = 1'b1;
        end
      end
      S_RD: begin
        waitN  = CNT_W'(1);
        stateN = S_WAIT;
      end
      S_WAIT: begin
        if (waitCnt == CNT_W'(RD_LAT)) begin
          if (mismatch) begin
            stb.capture = 1'b1;
            failN       = 1'b1;
            doneN       = 1'b1;
            stateN      = S_DONE;
          end else if (fillPass) begin
            if (!lastAddr) begin
              stb.incAddr = 1'b1;
              stateN      = S_RD;
            end else begin
              advPass = 1'b1;
            end
          end else if (!lastSub) begin
            stb.incSub = 1'b1;
            stateN     = S_WR;
          end else if (!lastAddr) begin
            stb.incAddr = 1'b1;
            stateN      = S_WR;
          end else begin
            advPass = 1'b1;
          end
        end else begin
          waitN = waitCnt + CNT_W'(1);
        end
        if (advPass) begin
          if (pass == PASS_FIB) begin
            doneN  = 1'b1;
            stateN = S_DONE;
          end else begin
            passN      = passT'(pass + 3'd1);
            stb.clrPos = 1'b1;
            stateN     = S_WR;
          end
        end
      end
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      pass    <= PASS_ZERO;
      waitCnt <= '0;
      done    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      state   <= stateN;
      pass    <= passN;
      waitCnt <= waitN;
      done    <= doneN;
      fail    <= failN;
    end
  end

  assign memWe = (state == S_WR);
  assign memRe = (state == S_RD);
  assign busy  = (state == S_WR) || (state == S_RD) || (state == S_WAIT);

  p_we_re_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe))
    else $error("write and read enable together");

  p_rd_then_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> !memRe && !memWe)
    else $error("memory access during read wait");

  p_pass_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    pass != $past(pass) |-> (pass == passT'($past(pass) + 3'd1)) || (pass == PASS_ZERO))
    else $error("pass order broken");

  p_fail_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> done && !busy)
    else $error("fail without done");

  p_hold_result_r10: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done && $stable(fail))
    else $error("result not held");

endmodule

// File: rtl/sramSelfTest.sv
module sramSelfTest
  import sramTestPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failExpect,
  output logic [DATA_W-1:0] failActual,
  output logic [2:0]        failPass,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memWe,
  output logic              memRe
);

  strobeT stb;
  passT   pass;
  logic   lastSub, lastAddr, mismatch;

  sramTestCtrl #(.RD_LAT(RD_LAT)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .lastSub(lastSub), .lastAddr(lastAddr), .mismatch(mismatch),
    .stb(stb), .pass(pass), .memWe(memWe), .memRe(memRe),
    .busy(busy), .done(done), .fail(fail)
  );

  sramTestDp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(11)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .pass(pass), .rdData(memRdata),
    .addr(memAddr), .pattern(memWdata),
    .lastSub(lastSub), .lastAddr(lastAddr), .mismatch(mismatch),
    .failAddr(failAddr), .failExp(failExpect), .failAct(failActual),
    .failPass(failPass)
  );

endmodule

// File: tb/tb_sramSelfTest.sv
module tb_sramSelfTest;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int LAT = 2;
  localparam int N = 1 << AW;
  localparam int RUN_CYC = N * (4 + 2*DW) * (2 + LAT) + 2 * N * (2 + LAT);
  localparam int NVEC = 8;

  // {mode[3:0], expFail, pass[2:0], addr[7:0], expect[7:0], actual[7:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    {4'd0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00},   // R4 clean memory
    {4'd1, 1'b1, 3'd5, 8'h00, 8'h0B, 8'h2B},   // R8 top address bit ignored
    {4'd2, 1'b1, 3'd1, 8'h00, 8'hFF, 8'hFE},   // R5 bit0 stuck low
    {4'd3, 1'b1, 3'd0, 8'h00, 8'h00, 8'h08},   // R5 bit3 stuck high
    {4'd4, 1'b1, 3'd3, 8'h00, 8'h02, 8'h00},   // R7 bits 1,3 wired-AND
    {4'd5, 1'b1, 3'd2, 8'h00, 8'h55, 8'h57},   // R6 bits 0,1 wired-OR
    {4'd6, 1'b1, 3'd4, 8'h00, 8'hEF, 8'hFF},   // R7 single-zero sensitive cell
    {4'd7, 1'b1, 3'd5, 8'h00, 8'h0B, 8'h2B}    // R8 upper address lines bridged
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic busy, done, fail, memWe, memRe;
  logic [AW-1:0] failAddr, memAddr;
  logic [DW-1:0] failExpect, failActual, memWdata, memRdata;
  logic [2:0] failPass;

  int checks = 0;
  int errors = 0;
  int faultMode = 0;
  int exclViol = 0;
  int cycTotal = 0;

  logic [DW-1:0] mem [N];
  logic [DW-1:0] rdPipe [LAT];

  always #2 clk = ~clk;

  sramSelfTest #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(LAT)) dut (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done), .fail(fail),
    .failAddr(failAddr), .failExpect(failExpect), .failActual(failActual),
    .failPass(failPass), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memWe(memWe), .memRe(memRe)
  );

  function automatic int effAddr(input int a);
    int b;
    if (faultMode == 1) return a & (N/2 - 1);
    if (faultMode == 7) begin
      b = ((a >> (AW-1)) & (a >> (AW-2))) & 1;
      return (a & (N/4 - 1)) | (b << (AW-2)) | (b << (AW-1));
    end
    return a;
  endfunction

  function automatic logic [DW-1:0] onWrite(input logic [DW-1:0] d);
    logic [DW-1:0] r = d;
    if (faultMode == 4) begin r[1] = d[1] & d[3]; r[3] = d[1] & d[3]; end
    if (faultMode == 5) begin r[0] = d[0] | d[1]; r[1] = d[0] | d[1]; end
    return r;
  endfunction

  function automatic logic [DW-1:0] onRead(input logic [DW-1:0] d);
    if (faultMode == 2) return d & 8'hFE;
    if (faultMode == 3) return d | 8'h08;
    if (faultMode == 6 && d == 8'hEF) return 8'hFF;
    return d;
  endfunction

  always @(posedge clk) begin
    if (memWe) mem[effAddr(int'(memAddr))] <= onWrite(memWdata);
    rdPipe[0] <= mem[effAddr(int'(memAddr))];
    for (int i = 1; i < LAT; i++) rdPipe[i] <= rdPipe[i-1];
  end
  assign memRdata = onRead(rdPipe[LAT-1]);

  always @(negedge clk) begin
    if (rstN && memWe && memRe) exclViol++;
    cycTotal++;
    if (cycTotal > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under 190000", cycTotal);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic runTest(input int mode, input bit midStart, output int cycles);
    int guard = 0;
    faultMode = mode;
    for (int i = 0; i < N; i++) mem[i] = 8'hC3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 0;
    while (!done && guard < 20000) begin
      if (busy) cycles++;
      @(negedge clk);
      start = midStart && (cycles == 100);
      guard++;
    end
    start = 1'b0;
  endtask

  initial begin
    int cyc;
    logic [DW-1:0] fa, fb, ft;
    int bad;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 fail", fail, 0);
    check("R1 enables", {memWe, memRe}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after release", {busy, done, fail}, 0);

    // vector table walk: R4 R5 R6 R7 R8 R10
    for (int v = 0; v < NVEC; v++) begin
      runTest(int'(VEC[v][31:28]), 1'b0, cyc);
      check($sformatf("R10 vec%0d done", v), done, 1);
      check($sformatf("R10 vec%0d fail", v), fail, int'(VEC[v][27]));
      check($sformatf("R10 vec%0d busy", v), busy, 0);
      if (VEC[v][27]) begin
        check($sformatf("R10 vec%0d pass code", v), failPass, int'(VEC[v][26:24]));
        check($sformatf("R10 vec%0d addr", v), failAddr, int'(VEC[v][23:16]));
        check($sformatf("R10 vec%0d expect", v), failExpect, int'(VEC[v][15:8]));
        check($sformatf("R10 vec%0d actual", v), failActual, int'(VEC[v][7:0]));
      end else begin
        // R4 R3: full run length with exact read timing
        check("R4 clean run length", cyc, RUN_CYC);
        // R9: memory holds the wrapped sequence seeded 1,1
        fa = 8'd1; fb = 8'd1; bad = 0;
        for (int i = 0; i < N; i++) begin
          if (mem[i] != fa) bad++;
          ft = fa + fb; fa = fb; fb = ft;
        end
        check("R9 sequence contents mismatches", bad, 0);
      end
    end

    // R10: result held while no start
    runTest(2, 1'b0, cyc);
    repeat (10) @(negedge clk);
    check("R10 held done/fail", {done, fail}, 2'b11);
    check("R10 held pass code", failPass, 1);

    // R2: restart from done-with-fail, and start while busy ignored
    runTest(0, 1'b1, cyc);
    check("R2 restart clears fail", fail, 0);
    check("R2 start while busy ignored", cyc, RUN_CYC);

    // R3: enables exclusive throughout
    check("R3 we/re overlap count", exclViol, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

endmodule